// File: doc/BRIEF.md
# ADC Sample Buffer Controller

This block sits between a byte-wide register bus and an analog-to-digital converter. It starts conversions when software asks for one and tracks whether the converter is busy. Each result lands in a small FIFO. Software reads the results back two bytes at a time. The FIFO reports empty, full and threshold flags, plus an overflow flag that stays set until software resets the FIFO.

A write-only command register holds one-shot strobes. They reset the FIFO, send a zero-scale reset to the D/A channels, clear one of three interrupt sources, or start a conversion. Exactly one command bit may be set in a write. A read-only status register, one offset below the command register, reports the three pending interrupts and the four FIFO flags. The timer, digital I/O, D/A and converter logic are outside this block and appear here only as strobe inputs and outputs. The reset is asynchronous and active low, and is released in step with the clock through a two-stage synchronizer.

Top module: `adc_buf_ctrl`

## Requirements
- R1: Reading address 0xE returns the status byte. Bit 6 is timer pending, bit 5 digital I/O pending, bit 4 A/D pending, bit 3 overflow, bit 2 full, bit 1 threshold and bit 0 empty. Bit 7 reads 0.
- R2: Out of reset the status reads 0x01. Writing 0x40 to address 0xF (FIFO reset) empties the FIFO, so that overflow, full and threshold read 0 (threshold reads 1 when the threshold register is 0) and empty reads 1.
- R3: A conversion-done strobe that arrives while the FIFO is full sets overflow. Overflow stays set through reads and further conversions until a FIFO reset.
- R4: A sample that arrives while the FIFO is full is discarded. The stored samples and their order are kept.
- R5: The threshold register at address 0x2 is readable and writable and holds log2(DEPTH) bits. The threshold flag is 1 when the fill level is at or above the register value, so a value of 0 keeps the flag at 1.
- R6: Full reads 1 exactly when DEPTH samples are stored. Empty reads 1 exactly when none are stored.
- R7: Address 0x0 returns the low byte of the oldest sample without removing it. Address 0x1 returns the upper sample bits and removes the sample. Both addresses return 0 when the FIFO is empty, and a read of an empty FIFO changes no flag.
- R8: A command write whose byte has more than one bit set is ignored entirely.
- R9: Writing 0x01 to address 0xF while the converter is idle drives adc_start_o high for one cycle and sets adc_busy_o. adc_busy_o stays 1 until adc_done_i, and a start written while busy is ignored.
- R10: Writing 0x20 to address 0xF pulses dac_zero_o for one cycle.
- R11: A one-cycle pulse on tmr_req_i, dio_req_i or adc_done_i sets the timer, digital I/O or A/D pending bit. Only the matching clear command clears it: 0x10 for timer, 0x08 for digital I/O, 0x04 for A/D. A request in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (pops on address 0x1) |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of the address |
| tmr_req_i | input | 1 | Timer interrupt request pulse |
| dio_req_i | input | 1 | Digital I/O interrupt request pulse |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_busy_o | output | 1 | Conversion in progress |
| adc_done_i | input | 1 | Conversion done pulse, pushes adc_data_i |
| adc_data_i | input | SAMPLE_W | Conversion result |
| dac_zero_o | output | 1 | D/A zero-scale reset pulse |

## Verification
The FIFO is driven in three ways: filled partway past a moved threshold, filled to full and then hit once more, and drained from empty. These separate a threshold compare that is off by one, overflow that is not sticky, and a full FIFO that overwrites its oldest entry. The command register gets single-bit writes, multi-bit writes and writes to an unused bit, which separates a proper one-hot check from a plain OR of the bits. Request and clear are also driven in the same cycle, and start is written while busy, to check which side wins in each case.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_SAMP_LO = 4'h0;
  localparam logic [ADDR_W-1:0] A_SAMP_HI = 4'h1;
  localparam logic [ADDR_W-1:0] A_THRESH  = 4'h2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'hE;
  localparam logic [ADDR_W-1:0] A_CMD     = 4'hF;

  localparam int C_START  = 0;
  localparam int C_CLR_AD = 2;
  localparam int C_CLR_IO = 3;
  localparam int C_CLR_TM = 4;
  localparam int C_DA_ZERO = 5;
  localparam int C_FLUSH  = 6;

  localparam int N_IRQ = 3;
  localparam int I_AD = 0;
  localparam int I_IO = 1;
  localparam int I_TM = 2;
endpackage

// File: rtl/cmd_strobe.sv
module cmd_strobe (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] cmd_o
);
  logic single_bit;

  always_comb begin
    single_bit = $onehot(wdata_i);
    cmd_o      = (wr_en_i && single_bit) ? wdata_i : 8'h00;
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(cmd_o)); // R8
  AST_MULTI_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($countones(wdata_i) > 1) |-> (cmd_o == 8'h00)); // R8
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic pend_q, pend_d;

    always_comb begin
      pend_d = pend_q;
      if (clr_i[g]) pend_d = 1'b0;
      if (req_i[g]) pend_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) pend_q <= 1'b0;
      else          pend_q <= pend_d;
    end

    assign pend_o[g] = pend_q;

    AST_REQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      req_i[g] |=> pend_o[g]); // R11
    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]); // R11
  end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     flush_i,
  input  logic                     push_i,
  input  logic [W-1:0]             data_i,
  input  logic                     pop_i,
  input  logic [$clog2(DEPTH)-1:0] thr_i,
  output logic [W-1:0]             head_o,
  output logic                     empty_o,
  output logic                     full_o,
  output logic                     thr_o,
  output logic                     ovf_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             do_push, do_pop;

  always_comb begin
    empty_o = (cnt_q == '0);
    full_o  = (cnt_q == CNT_FULL);
    thr_o   = (cnt_q >= {1'b0, thr_i});
    ovf_o   = ovf_q;
    head_o  = mem[rp_q];
    do_push = push_i && !full_o && !flush_i;
    do_pop  = pop_i && !empty_o && !flush_i;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (flush_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
      if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
      if (push_i && full_o) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= data_i;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    flush_i |=> (empty_o && !ovf_o && !full_o)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ovf_o && !flush_i) |=> ovf_o); // R3
  AST_FULL_SETS_OVF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (push_i && full_o && !flush_i) |=> ovf_o); // R3
  AST_FULL_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (push_i && full_o && !pop_i && !flush_i) |=> (full_o && $stable(head_o))); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(empty_o && full_o)); // R6
endmodule

// File: rtl/adc_buf_ctrl.sv
module adc_buf_ctrl
  import adc_buf_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 8,
  parameter int THR_INIT = 4
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  input  logic                tmr_req_i,
  input  logic                dio_req_i,
  output logic                adc_start_o,
  output logic                adc_busy_o,
  input  logic                adc_done_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                dac_zero_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic rst_meta, rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  logic [7:0]          cmd;
  logic [IDX_W-1:0]    thr_q, thr_d;
  logic                busy_q, busy_d, start_q, start_d, dac_q, dac_d;
  logic [N_IRQ-1:0]    irq_req, irq_clr, irq_pend;
  logic [SAMPLE_W-1:0] head;
  logic [15:0]         head_ext;
  logic                f_empty, f_full, f_thr, f_ovf, pop;

  cmd_strobe u_cmd (
    .clk_i(clk_i), .rst_n_i(rst_n),
    .wr_en_i(bus_wr_i && (bus_addr_i == A_CMD)),
    .wdata_i(bus_wdata_i), .cmd_o(cmd)
  );

  always_comb begin
    irq_req = '0;
    irq_clr = '0;
    irq_req[I_AD] = adc_done_i;
    irq_req[I_IO] = dio_req_i;
    irq_req[I_TM] = tmr_req_i;
    irq_clr[I_AD] = cmd[C_CLR_AD];
    irq_clr[I_IO] = cmd[C_CLR_IO];
    irq_clr[I_TM] = cmd[C_CLR_TM];
  end

  irq_pend #(.N(N_IRQ)) u_irq (
    .clk_i(clk_i), .rst_n_i(rst_n),
    .req_i(irq_req), .clr_i(irq_clr), .pend_o(irq_pend)
  );

  assign pop = bus_rd_i && (bus_addr_i == A_SAMP_HI);

  sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_n_i(rst_n),
    .flush_i(cmd[C_FLUSH]), .push_i(adc_done_i), .data_i(adc_data_i),
    .pop_i(pop), .thr_i(thr_q), .head_o(head),
    .empty_o(f_empty), .full_o(f_full), .thr_o(f_thr), .ovf_o(f_ovf)
  );

  always_comb begin
    thr_d   = thr_q;
    if (bus_wr_i && (bus_addr_i == A_THRESH)) thr_d = bus_wdata_i[IDX_W-1:0];
    start_d = cmd[C_START] && !busy_q;
    busy_d  = busy_q;
    if (adc_done_i) busy_d = 1'b0;
    if (start_d)    busy_d = 1'b1;
    dac_d   = cmd[C_DA_ZERO];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= IDX_W'(THR_INIT);
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      dac_q   <= 1'b0;
    end else begin
      thr_q   <= thr_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      dac_q   <= dac_d;
    end
  end

  assign adc_start_o = start_q;
  assign adc_busy_o  = busy_q;
  assign dac_zero_o  = dac_q;
  assign head_ext    = 16'(head);

  always_comb begin
    bus_rdata_o = 8'h00;
    unique case (bus_addr_i)
      A_SAMP_LO: bus_rdata_o = f_empty ? 8'h00 : head_ext[7:0];
      A_SAMP_HI: bus_rdata_o = f_empty ? 8'h00 : head_ext[15:8];
      A_THRESH:  bus_rdata_o = 8'(thr_q);
      A_STATUS:  bus_rdata_o = {1'b0, irq_pend[I_TM], irq_pend[I_IO], irq_pend[I_AD],
                                f_ovf, f_full, f_thr, f_empty};
      default:   bus_rdata_o = 8'h00;
    endcase
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    adc_start_o |-> adc_busy_o); // R9
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adc_busy_o && !adc_done_i) |=> adc_busy_o); // R9
  AST_DAC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    dac_zero_o |=> !dac_zero_o); // R10
endmodule

// File: tb/adc_buf_ctrl_test.sv
module adc_buf_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, tmr = 1'b0, dio = 1'b0, done = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [11:0] sdata = 12'h000;
  logic [7:0] rdata;
  logic start, busy, dzero;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  adc_buf_ctrl uut (
    .clk_i(clk), .rst_n_i(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tmr_req_i(tmr), .dio_req_i(dio), .adc_start_o(start), .adc_busy_o(busy),
    .adc_done_i(done), .adc_data_i(sdata), .dac_zero_o(dzero)
  );

  // {op[3], req[4], addr[4], data[16], expected[8]}
  // op: 0 write, 1 read+compare, 2 conversion done, 3 timer req, 4 dio req
  localparam int NV = 39;
  localparam logic [34:0] VEC [NV] = '{
    {3'd1, 4'd2,  4'hE, 16'h0000, 8'h01}, // R2 empty after reset
    {3'd2, 4'd11, 4'h0, 16'h0123, 8'h00},
    {3'd1, 4'd11, 4'hE, 16'h0000, 8'h10}, // R11 A/D pending set by done
    {3'd0, 4'd11, 4'hF, 16'h0004, 8'h00},
    {3'd1, 4'd11, 4'hE, 16'h0000, 8'h00}, // R11 clear A/D
    {3'd1, 4'd7,  4'h0, 16'h0000, 8'h23}, // R7 low byte peek
    {3'd1, 4'd7,  4'h1, 16'h0000, 8'h01}, // R7 high byte and pop
    {3'd1, 4'd6,  4'hE, 16'h0000, 8'h01}, // R6 empty again
    {3'd0, 4'd5,  4'h2, 16'h0002, 8'h00},
    {3'd1, 4'd5,  4'h2, 16'h0000, 8'h02}, // R5 threshold readback
    {3'd2, 4'd5,  4'h0, 16'h00AA, 8'h00},
    {3'd2, 4'd5,  4'h0, 16'h00BB, 8'h00},
    {3'd1, 4'd5,  4'hE, 16'h0000, 8'h12}, // R5 level 2 at threshold 2
    {3'd0, 4'd8,  4'hF, 16'h000C, 8'h00},
    {3'd1, 4'd8,  4'hE, 16'h0000, 8'h12}, // R8 two-bit command ignored
    {3'd0, 4'd1,  4'hF, 16'h0004, 8'h00},
    {3'd1, 4'd1,  4'hE, 16'h0000, 8'h02}, // R1 bit layout
    {3'd2, 4'd6,  4'h0, 16'h00C1, 8'h00},
    {3'd2, 4'd6,  4'h0, 16'h00C2, 8'h00},
    {3'd2, 4'd6,  4'h0, 16'h00C3, 8'h00},
    {3'd2, 4'd6,  4'h0, 16'h00C4, 8'h00},
    {3'd2, 4'd6,  4'h0, 16'h00C5, 8'h00},
    {3'd2, 4'd6,  4'h0, 16'h00C6, 8'h00},
    {3'd1, 4'd6,  4'hE, 16'h0000, 8'h16}, // R6 full at DEPTH
    {3'd2, 4'd3,  4'h0, 16'h00FF, 8'h00},
    {3'd1, 4'd3,  4'hE, 16'h0000, 8'h1E}, // R3 overflow on full
    {3'd1, 4'd4,  4'h0, 16'h0000, 8'hAA}, // R4 oldest kept
    {3'd1, 4'd4,  4'h1, 16'h0000, 8'h00}, // R4 pop oldest
    {3'd1, 4'd3,  4'hE, 16'h0000, 8'h1A}, // R3 overflow sticky
    {3'd0, 4'd5,  4'h2, 16'h0000, 8'h00},
    {3'd0, 4'd2,  4'hF, 16'h0040, 8'h00},
    {3'd1, 4'd2,  4'hE, 16'h0000, 8'h13}, // R2 flush, R5 threshold 0
    {3'd0, 4'd5,  4'h2, 16'h0004, 8'h00},
    {3'd1, 4'd7,  4'h1, 16'h0000, 8'h00}, // R7 empty reads 0
    {3'd1, 4'd7,  4'hE, 16'h0000, 8'h11}, // R7 empty pop changes nothing
    {3'd3, 4'd11, 4'h0, 16'h0000, 8'h00},
    {3'd1, 4'd11, 4'hE, 16'h0000, 8'h51}, // R11 timer pending
    {3'd4, 4'd11, 4'h0, 16'h0000, 8'h00},
    {3'd1, 4'd11, 4'hE, 16'h0000, 8'h71}  // R11 dio pending
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr = 0; rd = 0; done = 0; tmr = 0; dio = 0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    idle();
  endtask

  task automatic bus_read(input int req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); rd = 1; addr = a;
    #1 check(req, rdata, exp);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(9, {6'd0, start, busy}, 8'h00); // R9 idle out of reset
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][34:32];
      case (op)
        3'd0: bus_write(VEC[i][27:24], VEC[i][15:8]);
        3'd1: bus_read(int'(VEC[i][31:28]), VEC[i][27:24], VEC[i][7:0]);
        3'd2: begin @(negedge clk); done = 1; sdata = VEC[i][19:8]; idle(); end
        3'd3: begin @(negedge clk); tmr = 1; idle(); end
        default: begin @(negedge clk); dio = 1; idle(); end
      endcase
    end
    // R11 request and clear in the same cycle: request wins
    @(negedge clk); tmr = 1; wr = 1; addr = 4'hF; wdata = 8'h10;
    idle();
    bus_read(11, 4'hE, 8'h71);
    bus_write(4'hF, 8'h08);
    bus_write(4'hF, 8'h10);
    bus_read(11, 4'hE, 8'h11);
    // R9 start, busy, start while busy ignored
    bus_write(4'hF, 8'h01);
    check(9, {6'd0, start, busy}, 8'h03);
    @(negedge clk);
    check(9, {6'd0, start, busy}, 8'h01);
    bus_write(4'hF, 8'h01);
    check(9, {6'd0, start, busy}, 8'h01);
    @(negedge clk); done = 1; sdata = 12'h055; idle();
    check(9, {6'd0, start, busy}, 8'h00);
    // R10 D/A zero pulse
    bus_write(4'hF, 8'h20);
    check(10, {7'd0, dzero}, 8'h01);
    @(negedge clk);
    check(10, {7'd0, dzero}, 8'h00);
    // R8 multi-bit with D/A and start ignored
    bus_write(4'hF, 8'h21);
    check(8, {6'd0, start, dzero}, 8'h00);
    check(8, {7'd0, busy}, 8'h00);
    // R1 unused bit 7 command does nothing, status bit 7 reads 0
    bus_write(4'hF, 8'h80);
    bus_read(1, 4'hE, 8'h10);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule